// File: doc/BRIEF.md
# Host-Target Mailbox Register Interface

This block gives a processor a small memory-mapped mailbox for talking to a host or test harness. Two 64-bit registers make up the mailbox: an outbound command register ("to-host") and an inbound reply register ("from-host"). The processor reaches each register as two 32-bit words over a plain bus with an address, a write enable, write data and combinational read data.

When the processor completes a command by writing the upper word of the to-host register, the block decodes the 64-bit word into a device number, a command number and a 48-bit argument. The command can do one of three things. It can end a test, which raises a one-cycle exit pulse with a registered exit code. It can send one byte out on a console transmit stream that uses a valid/ready handshake. It can register a pending console read. Characters from a console receive stream are then placed in the from-host register, tagged with the upper 16 bits of the pending read request. Any command the block does not support still gets a reply of zero, so software polling the mailbox never hangs.

Top module: `hostmbx`

## Requirements
- R1: After a synchronous reset, both registers read zero on every half, `exit_pulse` and `con_tx_valid` are low, `fh_loading` is low, and the stored pending-read tag is zero.
- R2: With the default parameters, the to-host register sits at byte address 0x00 (bits 31:0) and 0x04 (bits 63:32), and the from-host register sits at 0x08 (bits 31:0) and 0x0C (bits 63:32). A read of any other address returns 0.
- R3: A write to the to-host low word is taken only when to-host is zero. It then loads {32'h0, wdata} and arms the upper-word write. If to-host is nonzero, the write leaves to-host unchanged and disarms the upper-word write, so the next write to the to-host high word has no effect.
- R4: An armed write to the to-host high word forms the command word to-host | (wdata << 32). In that word, device = bits 63:56, command = bits 55:48 and argument = bits 47:0. Device 0 with command 0 and argument bit 0 set raises `exit_pulse` for exactly one cycle, starting in the cycle after the write. `exit_code` becomes argument bits EXIT_W:1. From-host becomes {word[63:48], 48'h0} and to-host becomes 0.
- R5: Device 1 with command 1 raises `con_tx_valid` with `con_tx_data` = argument bits 7:0. Both are held until `con_tx_ready` is seen high. While the byte waits, to-host keeps the command word and writes to the to-host high word have no effect. On acceptance, from-host becomes {word[63:48], 48'h100 | byte} and to-host becomes 0.
- R6: Device 1 with command 0 stores bits 63:48 of the word as the pending-read tag and clears to-host. From-host is left unchanged.
- R7: Every other command word sets from-host to {word[63:48], 48'h0} and clears to-host, with no exit pulse and no transmit. This covers device 0 with command 0 and argument bit 0 clear, device 0 with any other command, device 1 with command 2 or higher, and devices 2 to 255.
- R8: In each cycle that `con_rx_valid` is high, from-host becomes {tag, 48'h100 | con_rx_data}, where tag is the pending-read tag. The block accepts a character every cycle and overwrites any unread one.
- R9: A write to the from-host low word loads {32'h0, wdata} and raises `fh_loading`. A write to the from-host high word ORs wdata into bits 63:32 and drops `fh_loading`.
- R10: When a processor write to from-host and a received character arrive in the same cycle, the processor write wins and the character is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address of the 32-bit word |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| exit_pulse | output | 1 | One-cycle test-exit indication |
| exit_code | output | EXIT_W | Exit code captured with the last exit pulse |
| con_tx_valid | output | 1 | Console transmit byte is valid |
| con_tx_data | output | 8 | Console transmit byte |
| con_tx_ready | input | 1 | Console sink accepts the byte |
| con_rx_valid | input | 1 | Console receive character is present |
| con_rx_data | input | 8 | Console receive character |
| fh_loading | output | 1 | From-host is partly written (low word loaded, high word pending) |

## Verification
Assertions check the following on every cycle:
- the exit pulse never lasts two cycles;
- a stalled transmit byte stays valid and does not change;
- a rejected low-word write leaves to-host intact;
- an accepted byte empties to-host;
- a lone received character lands in the low 48 bits of from-host;
- a from-host low write raises the loading flag.

Other behaviour shows only in the bench's scenarios:
- the full decode table, including the exact reply word for each device/command class;
- the way a rejected low write stalls the next high write;
- the tagging of received characters with the pending request;
- the priority between a processor write and a received character in the same cycle.

// File: rtl/hostmbx_pkg.sv
package hostmbx_pkg;

   localparam int WORD_W = 64;
   localparam int HALF_W = 32;

   localparam logic [7:0] DEV_TEST = 8'h00;
   localparam logic [7:0] DEV_CON  = 8'h01;
   localparam logic [7:0] OP_ZERO  = 8'h00;
   localparam logic [7:0] OP_ONE   = 8'h01;

   typedef struct packed {
      logic [7:0]  dev;
      logic [7:0]  op;
      logic [47:0] arg;
   } mbx_cmd_t;

   typedef enum logic [1:0] {
      ACT_REPLY0 = 2'd0,
      ACT_EXIT   = 2'd1,
      ACT_CON_TX = 2'd2,
      ACT_CON_RD = 2'd3
   } mbx_act_t;

   function automatic logic [47:0] char_resp(input logic [7:0] ch);
      return {39'h0, 1'b1, ch};
   endfunction

endpackage

// File: rtl/hostmbx_addr_dec.sv
module hostmbx_addr_dec #(
   parameter int ADDR_W       = 8,
   parameter int TOHOST_OFS   = 0,
   parameter int FROMHOST_OFS = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              sel_to_lo,
   output logic              sel_to_hi,
   output logic              sel_fr_lo,
   output logic              sel_fr_hi
);
   localparam logic [ADDR_W-1:0] TO_LO = ADDR_W'(TOHOST_OFS);
   localparam logic [ADDR_W-1:0] TO_HI = ADDR_W'(TOHOST_OFS + 4);
   localparam logic [ADDR_W-1:0] FR_LO = ADDR_W'(FROMHOST_OFS);
   localparam logic [ADDR_W-1:0] FR_HI = ADDR_W'(FROMHOST_OFS + 4);

   assign sel_to_lo = (addr == TO_LO);
   assign sel_to_hi = (addr == TO_HI);
   assign sel_fr_lo = (addr == FR_LO);
   assign sel_fr_hi = (addr == FR_HI);

   // R2
   always_comb begin
      onehot_sel_chk : assert ($onehot0({sel_to_lo, sel_to_hi, sel_fr_lo, sel_fr_hi}))
         else $error("address decode selected more than one word");
   end
endmodule

// File: rtl/hostmbx_cmd_dec.sv
module hostmbx_cmd_dec
   import hostmbx_pkg::*;
(
   input  logic [7:0] dev,
   input  logic [7:0] op,
   input  logic       arg_lsb,
   output mbx_act_t   act
);
   always_comb begin
      act = ACT_REPLY0;
      if (dev == DEV_TEST && op == OP_ZERO && arg_lsb) begin
         act = ACT_EXIT;
      end else if (dev == DEV_CON && op == OP_ZERO) begin
         act = ACT_CON_RD;
      end else if (dev == DEV_CON && op == OP_ONE) begin
         act = ACT_CON_TX;
      end
   end
endmodule

// File: rtl/hostmbx_tx_port.sv
module hostmbx_tx_port (
   input  logic       clk,
   input  logic       rst,
   input  logic       load,
   input  logic [7:0] load_byte,
   output logic       tx_valid,
   output logic [7:0] tx_data,
   input  logic       tx_ready,
   output logic       fire
);
   logic       valid_q;
   logic [7:0] data_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
         data_q  <= 8'h00;
      end else if (load) begin
         valid_q <= 1'b1;
         data_q  <= load_byte;
      end else if (valid_q && tx_ready) begin
         valid_q <= 1'b0;
      end
   end

   assign tx_valid = valid_q;
   assign tx_data  = data_q;
   assign fire     = valid_q && tx_ready;

   // R5
   tx_hold_chk : assert property (@(posedge clk) disable iff (rst)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)))
      else $error("transmit byte dropped or changed while stalled");
endmodule

// File: rtl/hostmbx.sv
module hostmbx
   import hostmbx_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int TOHOST_OFS   = 0,
   parameter int FROMHOST_OFS = 8,
   parameter int EXIT_W       = 31,
   parameter bit RDATA_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              exit_pulse,
   output logic [EXIT_W-1:0] exit_code,
   output logic              con_tx_valid,
   output logic [7:0]        con_tx_data,
   input  logic              con_tx_ready,
   input  logic              con_rx_valid,
   input  logic [7:0]        con_rx_data,
   output logic              fh_loading
);
   localparam int TAG_W = WORD_W - 48;

   initial begin
      offs_align_chk : assert ((TOHOST_OFS % 4 == 0) && (FROMHOST_OFS % 4 == 0))
         else $error("register offsets must be word aligned");
      offs_apart_chk : assert ((TOHOST_OFS + 8 <= FROMHOST_OFS) || (FROMHOST_OFS + 8 <= TOHOST_OFS))
         else $error("register windows overlap");
      offs_fit_chk : assert ((TOHOST_OFS + 4 < (1 << ADDR_W)) && (FROMHOST_OFS + 4 < (1 << ADDR_W)))
         else $error("register offsets exceed address width");
      exit_w_chk : assert (EXIT_W >= 1 && EXIT_W <= 47)
         else $error("EXIT_W out of range");
   end

   logic sel_to_lo, sel_to_hi, sel_fr_lo, sel_fr_hi;

   hostmbx_addr_dec #(
      .ADDR_W(ADDR_W), .TOHOST_OFS(TOHOST_OFS), .FROMHOST_OFS(FROMHOST_OFS)
   ) u_adec (
      .addr(bus_addr), .sel_to_lo(sel_to_lo), .sel_to_hi(sel_to_hi),
      .sel_fr_lo(sel_fr_lo), .sel_fr_hi(sel_fr_hi)
   );

   logic [WORD_W-1:0] tohost_q;
   logic [WORD_W-1:0] fromhost_q;
   logic [TAG_W-1:0]  pend_tag_q;
   logic              allow_q;
   logic              loading_q;
   logic              exit_q;
   logic [EXIT_W-1:0] code_q;

   logic [WORD_W-1:0] merged;
   mbx_cmd_t          cmd_w;
   mbx_act_t          act;
   logic              tx_fire;
   logic              lo_wr, lo_ok, hi_go, fr_lo_wr, fr_hi_wr, reply0;

   assign merged   = tohost_q | {bus_wdata, 32'h0};
   assign cmd_w    = mbx_cmd_t'(merged);
   assign lo_wr    = bus_we && sel_to_lo;
   assign lo_ok    = lo_wr && (tohost_q == '0);
   assign hi_go    = bus_we && sel_to_hi && allow_q && !con_tx_valid;
   assign fr_lo_wr = bus_we && sel_fr_lo;
   assign fr_hi_wr = bus_we && sel_fr_hi;
   assign reply0   = hi_go && (act == ACT_EXIT || act == ACT_REPLY0);

   hostmbx_cmd_dec u_cdec (
      .dev(cmd_w.dev), .op(cmd_w.op), .arg_lsb(cmd_w.arg[0]), .act(act)
   );

   hostmbx_tx_port u_tx (
      .clk(clk), .rst(rst),
      .load(hi_go && act == ACT_CON_TX), .load_byte(cmd_w.arg[7:0]),
      .tx_valid(con_tx_valid), .tx_data(con_tx_data),
      .tx_ready(con_tx_ready), .fire(tx_fire)
   );

   // to-host register, arming flag and pending-read tag
   always_ff @(posedge clk) begin
      if (rst) begin
         tohost_q   <= '0;
         allow_q    <= 1'b0;
         pend_tag_q <= '0;
      end else begin
         if (tx_fire) begin
            tohost_q <= '0;
         end
         if (lo_wr) begin
            allow_q <= (tohost_q == '0);
         end
         if (lo_ok) begin
            tohost_q <= {32'h0, bus_wdata};
         end
         if (hi_go) begin
            if (act == ACT_CON_TX) begin
               tohost_q <= merged;
            end else begin
               tohost_q <= '0;
            end
            if (act == ACT_CON_RD) begin
               pend_tag_q <= merged[WORD_W-1 -: TAG_W];
            end
         end
      end
   end

   // from-host register: processor write, command reply, transmit reply, received character
   always_ff @(posedge clk) begin
      if (rst) begin
         fromhost_q <= '0;
         loading_q  <= 1'b0;
      end else if (fr_lo_wr) begin
         fromhost_q <= {32'h0, bus_wdata};
         loading_q  <= 1'b1;
      end else if (fr_hi_wr) begin
         fromhost_q <= fromhost_q | {bus_wdata, 32'h0};
         loading_q  <= 1'b0;
      end else if (reply0) begin
         fromhost_q <= {merged[WORD_W-1 -: TAG_W], 48'h0};
      end else if (tx_fire) begin
         fromhost_q <= {tohost_q[WORD_W-1 -: TAG_W], char_resp(tohost_q[7:0])};
      end else if (con_rx_valid) begin
         fromhost_q <= {pend_tag_q, char_resp(con_rx_data)};
      end
   end

   // exit indication
   always_ff @(posedge clk) begin
      if (rst) begin
         exit_q <= 1'b0;
         code_q <= '0;
      end else begin
         exit_q <= hi_go && (act == ACT_EXIT);
         if (hi_go && act == ACT_EXIT) begin
            code_q <= merged[EXIT_W:1];
         end
      end
   end

   assign exit_pulse = exit_q;
   assign exit_code  = code_q;
   assign fh_loading = loading_q;

   // read path
   logic [31:0] rd_mux;
   always_comb begin
      rd_mux = 32'h0;
      if (sel_to_lo)      rd_mux = tohost_q[31:0];
      else if (sel_to_hi) rd_mux = tohost_q[63:32];
      else if (sel_fr_lo) rd_mux = fromhost_q[31:0];
      else if (sel_fr_hi) rd_mux = fromhost_q[63:32];
   end

   generate
      if (RDATA_REG) begin : g_rd_reg
         logic [31:0] rd_q;
         always_ff @(posedge clk) begin
            if (rst) rd_q <= 32'h0;
            else     rd_q <= rd_mux;
         end
         assign bus_rdata = rd_q;
      end else begin : g_rd_comb
         assign bus_rdata = rd_mux;
      end
   endgenerate

   // R4
   exit_single_chk : assert property (@(posedge clk) disable iff (rst)
      exit_pulse |=> !exit_pulse)
      else $error("exit pulse longer than one cycle");

   // R3
   to_reject_chk : assert property (@(posedge clk) disable iff (rst)
      (lo_wr && tohost_q != '0 && !tx_fire) |=> $stable(tohost_q))
      else $error("rejected low write changed to-host");

   // R5
   tx_ack_chk : assert property (@(posedge clk) disable iff (rst)
      tx_fire |=> (tohost_q == '0))
      else $error("to-host not emptied after byte accepted");

   // R8
   rx_load_chk : assert property (@(posedge clk) disable iff (rst)
      (con_rx_valid && !fr_lo_wr && !fr_hi_wr && !reply0 && !tx_fire)
      |=> (fromhost_q[47:0] == {39'h0, 1'b1, $past(con_rx_data)}))
      else $error("received character not placed in from-host");

   // R9
   fh_flag_chk : assert property (@(posedge clk) disable iff (rst)
      fr_lo_wr |=> fh_loading)
      else $error("loading flag not raised by from-host low write");
endmodule

// File: tb/hostmbx_test.sv
`timescale 1ns/1ps
module hostmbx_test;
   localparam int NV = 6;
   localparam logic [7:0] A_TL = 8'h00, A_TH = 8'h04, A_FL = 8'h08, A_FH = 8'h0C;

   // command word, expected from-host, exit expected, exit code
   localparam logic [63:0] TV_CMD [NV] = '{
      64'h0005_0000_0000_0007, 64'h0000_0000_0000_002B, 64'h0103_0000_0000_0041,
      64'h0000_0000_0000_1234, 64'h0701_0000_0000_00FF, 64'h0000_FFFF_FFFF_FFFF };
   localparam logic [63:0] TV_FROM [NV] = '{
      64'h0005_0000_0000_0000, 64'h0, 64'h0103_0000_0000_0000,
      64'h0, 64'h0701_0000_0000_0000, 64'h0 };
   localparam logic TV_EXIT [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
   localparam logic [30:0] TV_CODE [NV] = '{31'h0, 31'h15, 31'h0, 31'h0, 31'h0, 31'h7FFF_FFFF};

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  bus_addr = 8'h00;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        exit_pulse;
   logic [30:0] exit_code;
   logic        con_tx_valid;
   logic [7:0]  con_tx_data;
   logic        con_tx_ready = 1'b0;
   logic        con_rx_valid = 1'b0;
   logic [7:0]  con_rx_data = 8'h00;
   logic        fh_loading;

   int checks = 0;
   int errors = 0;
   logic [63:0] w;

   always #2 clk = ~clk;

   hostmbx uut (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .exit_pulse(exit_pulse),
      .exit_code(exit_code), .con_tx_valid(con_tx_valid), .con_tx_data(con_tx_data),
      .con_tx_ready(con_tx_ready), .con_rx_valid(con_rx_valid),
      .con_rx_data(con_rx_data), .fh_loading(fh_loading)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic rd64(input logic [7:0] lo, output logic [63:0] d);
      logic [31:0] l, h;
      rd(lo, l);
      rd(lo + 8'h4, h);
      d = {h, l};
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      @(negedge clk); @(negedge clk); rst = 1'b0;
   endtask

   task automatic rx(input logic [7:0] c);
      @(negedge clk); con_rx_valid = 1'b1; con_rx_data = c;
      @(negedge clk); con_rx_valid = 1'b0;
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog expired (all requirements)");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] r;
      do_reset();
      // R1 reset state
      rd64(A_TL, w); chk("R1 to-host after reset", w, 64'h0);
      rd64(A_FL, w); chk("R1 from-host after reset", w, 64'h0);
      chk("R1 outputs after reset", {61'h0, exit_pulse, con_tx_valid, fh_loading}, 64'h0);

      // R4 / R7 decode table
      for (int i = 0; i < NV; i++) begin
         wr(A_TL, TV_CMD[i][31:0]);
         wr(A_TH, TV_CMD[i][63:32]);
         chk("R4 R7 exit pulse", {63'h0, exit_pulse}, {63'h0, TV_EXIT[i]});
         if (TV_EXIT[i]) chk("R4 exit code", {33'h0, exit_code}, {33'h0, TV_CODE[i]});
         chk("R7 no transmit", {63'h0, con_tx_valid}, 64'h0);
         @(negedge clk);
         chk("R4 exit pulse one cycle", {63'h0, exit_pulse}, 64'h0);
         rd64(A_FL, w); chk("R4 R7 from-host reply", w, TV_FROM[i]);
         rd64(A_TL, w); chk("R4 R7 to-host cleared", w, 64'h0);
      end

      // R5 console transmit with stall
      wr(A_TL, 32'h0000_0041);
      wr(A_TH, 32'h0101_0000);
      chk("R5 tx valid", {63'h0, con_tx_valid}, 64'h1);
      chk("R5 tx byte", {56'h0, con_tx_data}, 64'h41);
      repeat (3) @(negedge clk);
      chk("R5 tx held", {55'h0, con_tx_valid, con_tx_data}, 64'h141);
      wr(A_TH, 32'h0200_0000);
      rd64(A_TL, w); chk("R5 high write ignored while busy", w, 64'h0101_0000_0000_0041);
      @(negedge clk); con_tx_ready = 1'b1;
      @(negedge clk); con_tx_ready = 1'b0;
      chk("R5 tx dropped after accept", {63'h0, con_tx_valid}, 64'h0);
      rd64(A_FL, w); chk("R5 from-host tx reply", w, 64'h0101_0000_0000_0141);
      rd64(A_TL, w); chk("R5 to-host cleared", w, 64'h0);

      // R6 console read request, then R8 characters
      wr(A_TL, 32'h5678_9ABC);
      wr(A_TH, 32'h0100_1234);
      rd64(A_FL, w); chk("R6 from-host unchanged", w, 64'h0101_0000_0000_0141);
      rd64(A_TL, w); chk("R6 to-host cleared", w, 64'h0);
      rx(8'h5A);
      rd64(A_FL, w); chk("R8 rx tagged", w, 64'h0100_0000_0000_015A);
      @(negedge clk); con_rx_valid = 1'b1; con_rx_data = 8'h31;
      @(negedge clk); con_rx_data = 8'h32;
      @(negedge clk); con_rx_valid = 1'b0;
      rd64(A_FL, w); chk("R8 rx overwrite", w, 64'h0100_0000_0000_0132);

      // R9 processor writes to from-host
      wr(A_FL, 32'hDEAD_BEEF);
      chk("R9 loading set", {63'h0, fh_loading}, 64'h1);
      rd64(A_FL, w); chk("R9 low load", w, 64'h0000_0000_DEAD_BEEF);
      wr(A_FH, 32'h0000_1111);
      chk("R9 loading clear", {63'h0, fh_loading}, 64'h0);
      rd64(A_FL, w); chk("R9 high OR", w, 64'h0000_1111_DEAD_BEEF);

      // R2 address map
      rd(A_FH, r); chk("R2 from-host high word", {32'h0, r}, 64'h1111);
      rd(8'h10, r); chk("R2 unmapped read", {32'h0, r}, 64'h0);
      rd(8'h0A, r); chk("R2 unaligned read", {32'h0, r}, 64'h0);

      // R10 processor write beats received character
      @(negedge clk);
      bus_addr = A_FL; bus_we = 1'b1; bus_wdata = 32'h1234_5678;
      con_rx_valid = 1'b1; con_rx_data = 8'h77;
      @(negedge clk);
      bus_we = 1'b0; con_rx_valid = 1'b0;
      rd64(A_FL, w); chk("R10 bus write wins", w, 64'h0000_0000_1234_5678);

      // R3 rejected low write disarms the high write
      wr(A_TL, 32'h0000_0055);
      wr(A_TL, 32'h0000_0066);
      rd64(A_TL, w); chk("R3 low write rejected", w, 64'h0000_0000_0000_0055);
      wr(A_TH, 32'h0000_0000);
      rd64(A_TL, w); chk("R3 high write ignored", w, 64'h0000_0000_0000_0055);
      rd64(A_FL, w); chk("R3 from-host untouched", w, 64'h0000_0000_1234_5678);

      // R1 second reset, pending tag back to zero (R8)
      do_reset();
      rd64(A_TL, w); chk("R1 to-host after second reset", w, 64'h0);
      chk("R1 loading after second reset", {63'h0, fh_loading}, 64'h0);
      rx(8'h21);
      rd64(A_FL, w); chk("R1 R8 pending tag cleared", w, 64'h0000_0000_0000_0121);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule